// File: doc/BRIEF.md
# Rename Stage Stall Controller

This block steers one thread of a register-rename pipeline stage through its stall states. It watches a single instruction slot arriving from decode, and it watches stall, credit and squash indications from the downstream and retirement stages. Each accepted instruction leaves on a registered output slot. When renaming cannot proceed, arrivals are parked in a skid buffer. That buffer is drained oldest-first, ahead of any new arrival, once the stall clears. The block also sends one-cycle block and unblock pulses back toward decode.

An instruction flagged to serialize before itself is held back until the reorder buffer is empty and nothing is still travelling between rename and dispatch. An instruction flagged to serialize after itself makes its successor wait in the same way. A squash from retirement empties the buffer and drops the current arrival. A held serializing instruction survives the squash only if it is not younger than the squash point. If it survives, the controller goes back to waiting on it once the squash has settled. The register mapping is outside this block, so each instruction is carried as an opaque tag with a sequence number.

Top module: `rn_stall_ctrl`

## Requirements
- R1: After reset, `state_o` is 0 (idle), `skid_level` is 0, and `out_valid`, `dec_block`, `dec_unblock` and `skid_overflow` are all low. State codes are: 0 idle, 1 running, 2 blocked, 3 unblocking, 4 squashing, 5 serialize-wait.
- R2: The inputs are ranked per cycle. `squash` has the highest rank. Next comes `rob_squashing`, which sets state 4 and drops the arrival without issuing anything. The stall conditions rank below both, so a squash together with a stall still lands in state 4.
- R3: A cycle is a stall cycle when any of these holds: `later_block` is high, `commit_block` is high, a two's-complement credit (`rob_cred`, `iq_cred` or `lsq_cred`) is zero or negative, `regs_ok` is low, or the state is 5 while `rob_empty` and `pipe_idle` are not both high. In a stall cycle the arrival is appended to the skid buffer. The state becomes 2, except that state 5 stays at 5. `dec_block` pulses only if the state was neither 2 nor 5.
- R4: In state 2, a cycle with no squash and no stall moves the state to 3, and that cycle's arrival is appended to the buffer.
- R5: In state 3, one instruction per cycle is issued from the buffer front, in arrival order, and new arrivals are appended behind it. When an issuing cycle leaves the buffer empty, the state becomes 1 and `dec_unblock` pulses.
- R6: The skid buffer holds 2*LAG*DEC_W+REN_W entries. An entry pushed into a full buffer is lost, and `skid_overflow` goes high and stays high until reset.
- R7: When an instruction whose serialize-before flag is set reaches the head of renaming, it is held and not issued. The state becomes 5 and `dec_block` pulses. The state stays at 5 until `rob_empty` and `pipe_idle` are both high and no other stall condition holds.
- R8: When state 5 is released, the held instruction has its serialize flags cleared. If the buffer is not empty, the held instruction goes to the buffer front and the state becomes 3. If the buffer is empty, the held instruction is issued that cycle. In that case an arrival in the same cycle is buffered and the state becomes 3; with no arrival, the state becomes 1 and `dec_unblock` pulses.
- R9: After an instruction with the serialize-after flag is issued, the next instruction to reach renaming is treated as serialize-before. This does not apply if `rob_empty` and `pipe_idle` are both high in that cycle, and the mark is cleared either way.
- R10: A squash empties the buffer, drops the arrival and sets state 4. In state 5, a held instruction whose sequence number is at most `squash_seq` is kept for later resumption. Otherwise the held instruction is discarded, and `dec_unblock` pulses if the state was 2, 3 or 5.
- R11: Once squashing ends (no `squash`, no `rob_squashing`), a kept instruction puts the state back to 5 with a `dec_block` pulse. Otherwise the state becomes 1 and that cycle's arrival is issued.
- R12: In states 0 and 1, with no stall, an arrival is issued on `out_tag`/`out_seq` with `out_valid` in the next cycle, and the state becomes 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An instruction arrives from decode this cycle |
| in_tag | input | TAG_W | Opaque instruction tag |
| in_seq | input | SEQ_W | Instruction sequence number |
| in_ser_before | input | 1 | Instruction must wait for an empty reorder buffer |
| in_ser_after | input | 1 | Successor must wait for an empty reorder buffer |
| squash | input | 1 | Squash request from retirement |
| squash_seq | input | SEQ_W | Youngest sequence number that survives the squash |
| rob_squashing | input | 1 | Reorder buffer is still squashing |
| later_block | input | 1 | Downstream stage asks rename to stall |
| commit_block | input | 1 | Retirement asks rename to stall |
| rob_cred | input | CRED_W | Reorder-buffer credits, two's complement |
| iq_cred | input | CRED_W | Issue-queue credits, two's complement |
| lsq_cred | input | CRED_W | Load/store-queue credits, two's complement |
| regs_ok | input | 1 | Enough free physical registers |
| rob_empty | input | 1 | Reorder buffer is empty |
| pipe_idle | input | 1 | No renamed instruction awaits dispatch |
| out_valid | output | 1 | Instruction issued to the next stage |
| out_tag | output | TAG_W | Tag of the issued instruction |
| out_seq | output | SEQ_W | Sequence number of the issued instruction |
| dec_block | output | 1 | One-cycle block pulse to decode |
| dec_unblock | output | 1 | One-cycle unblock pulse to decode |
| state_o | output | 3 | Controller state code |
| skid_level | output | CNT_W | Skid buffer occupancy |
| skid_overflow | output | 1 | Sticky skid buffer overflow flag |

## Verification
Plain streams of arrivals separate an idle controller from a running one. Stalls from each source separate the credit checks, which compare with zero and with negative values, from the block inputs, and they show whether the block pulse is suppressed. Serialize-before cases are run with the buffer empty and again with it occupied, and with the reorder buffer or the in-flight count holding the release. Together these show the direct-issue and front-reinsertion paths apart. Squashes arrive in serialize-wait with the held number exactly equal to the squash point and just above it, and again from the blocked state. A long stall runs the buffer past its capacity.

// File: rtl/rn_stall_pkg.sv
package rn_stall_pkg;

   typedef enum logic [2:0] {
      RS_IDLE     = 3'd0,
      RS_RUN      = 3'd1,
      RS_BLOCKED  = 3'd2,
      RS_UNBLOCK  = 3'd3,
      RS_SQUASH   = 3'd4,
      RS_SERIAL   = 3'd5
   } rs_state_e;

   typedef enum logic [2:0] {
      ACT_FLUSH,
      ACT_HOLD_SQ,
      ACT_STALL,
      ACT_RESUME,
      ACT_SETTLE,
      ACT_RELEASE,
      ACT_STEP
   } rs_act_e;

   function automatic int skid_cap(input int lag, input int dec_w, input int ren_w);
      return 2 * lag * dec_w + ren_w;
   endfunction

endpackage

// File: rtl/rn_skid_buf.sv
module rn_skid_buf #(
   parameter int W     = 8,
   parameter int DEPTH = 5,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             pop,
   input  logic             push_front,
   input  logic [W-1:0]     front_d,
   input  logic             push_back,
   input  logic [W-1:0]     back_d,
   output logic [W-1:0]     head,
   output logic [CNT_W-1:0] level,
   output logic             lost
);

   generate
      if (DEPTH < 1) begin : g_bad_depth
         $error("rn_skid_buf: DEPTH must be at least 1");
      end
      if (W < 1) begin : g_bad_width
         $error("rn_skid_buf: W must be at least 1");
      end
   endgenerate

   logic [W-1:0]     slot_q [DEPTH];
   logic [W-1:0]     after_pop [DEPTH];
   logic [W-1:0]     after_front [DEPTH];
   logic [W-1:0]     after_back [DEPTH];
   logic [CNT_W-1:0] lvl_q, lvl_pop, lvl_front, lvl_back;
   logic             front_ok, back_ok;

   assign lvl_pop   = lvl_q - CNT_W'(pop);
   assign front_ok  = push_front && (lvl_pop < CNT_W'(DEPTH));
   assign lvl_front = lvl_pop + CNT_W'(front_ok);
   assign back_ok   = push_back && (lvl_front < CNT_W'(DEPTH));
   assign lvl_back  = lvl_front + CNT_W'(back_ok);

   genvar gi;
   generate
      for (gi = 0; gi < DEPTH; gi++) begin : g_slot
         if (gi == DEPTH - 1) begin : g_tail
            assign after_pop[gi] = pop ? '0 : slot_q[gi];
         end else begin : g_mid
            assign after_pop[gi] = pop ? slot_q[gi+1] : slot_q[gi];
         end
         if (gi == 0) begin : g_first
            assign after_front[gi] = front_ok ? front_d : after_pop[gi];
         end else begin : g_rest
            assign after_front[gi] = front_ok ? after_pop[gi-1] : after_pop[gi];
         end
         assign after_back[gi] = (back_ok && lvl_front == CNT_W'(gi)) ? back_d : after_front[gi];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lvl_q <= '0;
         for (int k = 0; k < DEPTH; k++) slot_q[k] <= '0;
      end else if (flush) begin
         lvl_q <= '0;
      end else begin
         lvl_q <= lvl_back;
         for (int k = 0; k < DEPTH; k++) slot_q[k] <= after_back[k];
      end
   end

   assign head  = slot_q[0];
   assign level = lvl_q;
   assign lost  = !flush && ((push_front && !front_ok) || (push_back && !back_ok));

endmodule

// File: rtl/rn_stall_arbiter.sv
module rn_stall_arbiter
   import rn_stall_pkg::*;
#(
   parameter int CRED_W = 6
) (
   input  rs_state_e         state,
   input  logic              squash,
   input  logic              rob_squashing,
   input  logic              later_block,
   input  logic              commit_block,
   input  logic [CRED_W-1:0] rob_cred,
   input  logic [CRED_W-1:0] iq_cred,
   input  logic [CRED_W-1:0] lsq_cred,
   input  logic              regs_ok,
   input  logic              quiet,
   output rs_act_e           act
);

   localparam int NCRED = 3;

   logic [CRED_W-1:0] cred [NCRED];
   logic [NCRED-1:0]  dry;
   logic              stall;

   assign cred[0] = rob_cred;
   assign cred[1] = iq_cred;
   assign cred[2] = lsq_cred;

   genvar gc;
   generate
      for (gc = 0; gc < NCRED; gc++) begin : g_cred
         assign dry[gc] = cred[gc][CRED_W-1] || (cred[gc] == '0);
      end
   endgenerate

   assign stall = later_block || commit_block || (|dry) || !regs_ok ||
                  (state == RS_SERIAL && !quiet);

   always_comb begin
      if (squash)                   act = ACT_FLUSH;
      else if (rob_squashing)       act = ACT_HOLD_SQ;
      else if (stall)               act = ACT_STALL;
      else if (state == RS_BLOCKED) act = ACT_RESUME;
      else if (state == RS_SQUASH)  act = ACT_SETTLE;
      else if (state == RS_SERIAL)  act = ACT_RELEASE;
      else                          act = ACT_STEP;
   end

endmodule

// File: rtl/rn_stall_ctrl.sv
module rn_stall_ctrl
   import rn_stall_pkg::*;
#(
   parameter int TAG_W  = 8,
   parameter int SEQ_W  = 16,
   parameter int CRED_W = 6,
   parameter int LAG    = 2,
   parameter int DEC_W  = 1,
   parameter int REN_W  = 1,
   localparam int SKID_DEPTH = skid_cap(LAG, DEC_W, REN_W),
   localparam int CNT_W      = $clog2(SKID_DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [TAG_W-1:0]  in_tag,
   input  logic [SEQ_W-1:0]  in_seq,
   input  logic              in_ser_before,
   input  logic              in_ser_after,
   input  logic              squash,
   input  logic [SEQ_W-1:0]  squash_seq,
   input  logic              rob_squashing,
   input  logic              later_block,
   input  logic              commit_block,
   input  logic [CRED_W-1:0] rob_cred,
   input  logic [CRED_W-1:0] iq_cred,
   input  logic [CRED_W-1:0] lsq_cred,
   input  logic              regs_ok,
   input  logic              rob_empty,
   input  logic              pipe_idle,
   output logic              out_valid,
   output logic [TAG_W-1:0]  out_tag,
   output logic [SEQ_W-1:0]  out_seq,
   output logic              dec_block,
   output logic              dec_unblock,
   output logic [2:0]        state_o,
   output logic [CNT_W-1:0]  skid_level,
   output logic              skid_overflow
);

   localparam int ENT_W  = TAG_W + SEQ_W + 2;
   localparam int ID_W   = TAG_W + SEQ_W;
   localparam int SB_BIT = ID_W;
   localparam int SA_BIT = ID_W + 1;

   generate
      if (TAG_W < 1 || SEQ_W < 2) begin : g_bad_ids
         $error("rn_stall_ctrl: TAG_W >= 1 and SEQ_W >= 2 required");
      end
      if (CRED_W < 2) begin : g_bad_cred
         $error("rn_stall_ctrl: CRED_W must hold a sign bit and a magnitude");
      end
      if (LAG < 1 || DEC_W < 1 || REN_W < 1) begin : g_bad_sizing
         $error("rn_stall_ctrl: LAG, DEC_W and REN_W must be positive");
      end
   endgenerate

   rs_state_e        state, st_n;
   rs_act_e          act;
   logic [ENT_W-1:0] arr, src, held_q, hd_n, held_clean, sk_head, pf_d;
   logic             held_v, hv_n, resume_q, rs_n, pend_q, pd_n;
   logic             ov_n, bk_n, ub_n, ovf_q;
   logic [ID_W-1:0]  out_q, od_n;
   logic             fl, pop, pf, pb, sk_lost, use_sk, src_v, quiet, do_step, to_ser;
   logic [CNT_W-1:0] sk_lvl, after_cnt;

   assign arr        = {in_ser_after, in_ser_before, in_seq, in_tag};
   assign held_clean = {2'b00, held_q[ID_W-1:0]};
   assign quiet      = rob_empty && pipe_idle;
   assign use_sk     = (sk_lvl != '0);
   assign src        = use_sk ? sk_head : arr;
   assign src_v      = use_sk || in_valid;
   assign after_cnt  = sk_lvl - CNT_W'(use_sk) + CNT_W'(use_sk && in_valid);

   rn_stall_arbiter #(.CRED_W(CRED_W)) u_arb (
      .state(state), .squash(squash), .rob_squashing(rob_squashing),
      .later_block(later_block), .commit_block(commit_block),
      .rob_cred(rob_cred), .iq_cred(iq_cred), .lsq_cred(lsq_cred),
      .regs_ok(regs_ok), .quiet(quiet), .act(act)
   );

   rn_skid_buf #(.W(ENT_W), .DEPTH(SKID_DEPTH)) u_skid (
      .clk(clk), .rst_n(rst_n), .flush(fl), .pop(pop),
      .push_front(pf), .front_d(pf_d), .push_back(pb), .back_d(arr),
      .head(sk_head), .level(sk_lvl), .lost(sk_lost)
   );

   always_comb begin
      st_n    = state;
      ov_n    = 1'b0;
      od_n    = out_q;
      bk_n    = 1'b0;
      ub_n    = 1'b0;
      hv_n    = held_v;
      hd_n    = held_q;
      rs_n    = resume_q;
      pd_n    = pend_q;
      fl      = 1'b0;
      pop     = 1'b0;
      pf      = 1'b0;
      pb      = 1'b0;
      pf_d    = held_clean;
      do_step = 1'b0;
      to_ser  = 1'b0;
      unique case (act)
         ACT_FLUSH: begin
            fl   = 1'b1;
            st_n = RS_SQUASH;
            if (state == RS_SERIAL) begin
               if (held_v && held_q[ID_W-1:TAG_W] <= squash_seq) begin
                  rs_n = 1'b1;
               end else begin
                  hv_n = 1'b0;
                  rs_n = 1'b0;
                  ub_n = 1'b1;
               end
            end else if (state != RS_SQUASH) begin
               hv_n = 1'b0;
               rs_n = 1'b0;
               ub_n = (state == RS_BLOCKED) || (state == RS_UNBLOCK);
            end
         end
         ACT_HOLD_SQ: st_n = RS_SQUASH;
         ACT_STALL: begin
            pb = in_valid;
            if (state == RS_SQUASH && resume_q) begin
               st_n = RS_SERIAL;
               rs_n = 1'b0;
               bk_n = 1'b1;
            end else begin
               bk_n = (state != RS_BLOCKED) && (state != RS_SERIAL);
               if (state != RS_SERIAL) st_n = RS_BLOCKED;
            end
         end
         ACT_RESUME: begin
            pb   = in_valid;
            st_n = RS_UNBLOCK;
         end
         ACT_SETTLE: begin
            if (resume_q) begin
               st_n = RS_SERIAL;
               rs_n = 1'b0;
               bk_n = 1'b1;
               pb   = in_valid;
            end else begin
               do_step = 1'b1;
            end
         end
         ACT_RELEASE: begin
            hv_n = 1'b0;
            pb   = in_valid;
            if (use_sk) begin
               pf   = 1'b1;
               st_n = RS_UNBLOCK;
            end else begin
               ov_n = 1'b1;
               od_n = held_q[ID_W-1:0];
               if (in_valid) begin
                  st_n = RS_UNBLOCK;
               end else begin
                  st_n = RS_RUN;
                  ub_n = 1'b1;
               end
            end
         end
         default: do_step = 1'b1;
      endcase

      if (do_step) begin
         if (use_sk) begin
            pop = 1'b1;
            pb  = in_valid;
         end
         if (src_v) begin
            pd_n = 1'b0;
            if (src[SB_BIT] || (pend_q && !quiet)) begin
               hv_n   = 1'b1;
               hd_n   = src;
               st_n   = RS_SERIAL;
               bk_n   = 1'b1;
               to_ser = 1'b1;
            end else begin
               ov_n = 1'b1;
               od_n = src[ID_W-1:0];
               pd_n = src[SA_BIT];
            end
         end
         if (!to_ser) begin
            if (state == RS_UNBLOCK) begin
               if (after_cnt == '0) begin
                  st_n = RS_RUN;
                  ub_n = 1'b1;
               end
            end else if (src_v || state == RS_SQUASH) begin
               st_n = RS_RUN;
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= RS_IDLE;
         out_valid <= 1'b0;
         out_q    <= '0;
         dec_block <= 1'b0;
         dec_unblock <= 1'b0;
         held_v   <= 1'b0;
         held_q   <= '0;
         resume_q <= 1'b0;
         pend_q   <= 1'b0;
         ovf_q    <= 1'b0;
      end else begin
         state    <= st_n;
         out_valid <= ov_n;
         out_q    <= od_n;
         dec_block <= bk_n;
         dec_unblock <= ub_n;
         held_v   <= hv_n;
         held_q   <= hd_n;
         resume_q <= rs_n;
         pend_q   <= pd_n;
         ovf_q    <= ovf_q || sk_lost;
      end
   end

   assign out_tag       = out_q[TAG_W-1:0];
   assign out_seq       = out_q[ID_W-1:TAG_W];
   assign state_o       = state;
   assign skid_level    = sk_lvl;
   assign skid_overflow = ovf_q;

endmodule

// File: rtl/rn_stall_ctrl_chk.sv
module rn_stall_ctrl_chk #(
   parameter int CAP    = 5,
   parameter int CRED_W = 6,
   parameter int CNT_W  = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              squash,
   input logic              rob_squashing,
   input logic              later_block,
   input logic              commit_block,
   input logic [CRED_W-1:0] rob_cred,
   input logic [CRED_W-1:0] iq_cred,
   input logic [CRED_W-1:0] lsq_cred,
   input logic              regs_ok,
   input logic              rob_empty,
   input logic              out_valid,
   input logic              dec_block,
   input logic              dec_unblock,
   input logic [2:0]        state_o,
   input logic [CNT_W-1:0]  skid_level
);

   logic go;
   assign go = !later_block && !commit_block && regs_ok &&
               !rob_cred[CRED_W-1] && (rob_cred != '0) &&
               !iq_cred[CRED_W-1]  && (iq_cred != '0) &&
               !lsq_cred[CRED_W-1] && (lsq_cred != '0);

   p_pulse_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !(dec_block && dec_unblock));

   p_robsq_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (rob_squashing && !squash) |=> (state_o == 3'd4 && !out_valid));

   p_no_repeat_block_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == 3'd2) |=> !dec_block);

   p_resume_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == 3'd2 && !squash && !rob_squashing && go) |=> (state_o == 3'd3));

   p_unblock_target_r5: assert property (@(posedge clk) disable iff (!rst_n)
      dec_unblock |-> (state_o == 3'd1 || state_o == 3'd4));

   p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
      skid_level <= CNT_W'(CAP));

   p_ser_wait_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == 3'd5 && !rob_empty && !squash && !rob_squashing)
      |=> (state_o == 3'd5 && !out_valid));

   p_flush_r10: assert property (@(posedge clk) disable iff (!rst_n)
      squash |=> (state_o == 3'd4 && skid_level == '0 && !out_valid));

endmodule

bind rn_stall_ctrl rn_stall_ctrl_chk #(
   .CAP(SKID_DEPTH), .CRED_W(CRED_W), .CNT_W(CNT_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .squash(squash), .rob_squashing(rob_squashing),
   .later_block(later_block), .commit_block(commit_block),
   .rob_cred(rob_cred), .iq_cred(iq_cred), .lsq_cred(lsq_cred),
   .regs_ok(regs_ok), .rob_empty(rob_empty), .out_valid(out_valid),
   .dec_block(dec_block), .dec_unblock(dec_unblock),
   .state_o(state_o), .skid_level(skid_level)
);

// File: tb/rn_stall_ctrl_test.sv
module rn_stall_ctrl_test;

   localparam int CLK_NS = 10;
   localparam int TAG_W  = 8;
   localparam int SEQ_W  = 16;
   localparam int CRED_W = 6;
   localparam int LAG    = 2;
   localparam int DEC_W  = 1;
   localparam int REN_W  = 1;
   localparam int CAP    = 2 * LAG * DEC_W + REN_W;
   localparam int CNT_W  = $clog2(CAP + 1);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #(CLK_NS/2) clk = ~clk;

   logic              in_valid = 0, in_ser_before = 0, in_ser_after = 0;
   logic [TAG_W-1:0]  in_tag = '0;
   logic [SEQ_W-1:0]  in_seq = '0, squash_seq = '0;
   logic              squash = 0, rob_squashing = 0, later_block = 0, commit_block = 0;
   logic [CRED_W-1:0] rob_cred = 6'd4, iq_cred = 6'd4, lsq_cred = 6'd4;
   logic              regs_ok = 1, rob_empty = 1, pipe_idle = 1;
   logic              out_valid, dec_block, dec_unblock, skid_overflow;
   logic [TAG_W-1:0]  out_tag;
   logic [SEQ_W-1:0]  out_seq;
   logic [2:0]        state_o;
   logic [CNT_W-1:0]  skid_level;

   rn_stall_ctrl #(.TAG_W(TAG_W), .SEQ_W(SEQ_W), .CRED_W(CRED_W),
                   .LAG(LAG), .DEC_W(DEC_W), .REN_W(REN_W)) uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_tag(in_tag), .in_seq(in_seq),
      .in_ser_before(in_ser_before), .in_ser_after(in_ser_after),
      .squash(squash), .squash_seq(squash_seq), .rob_squashing(rob_squashing),
      .later_block(later_block), .commit_block(commit_block),
      .rob_cred(rob_cred), .iq_cred(iq_cred), .lsq_cred(lsq_cred),
      .regs_ok(regs_ok), .rob_empty(rob_empty), .pipe_idle(pipe_idle),
      .out_valid(out_valid), .out_tag(out_tag), .out_seq(out_seq),
      .dec_block(dec_block), .dec_unblock(dec_unblock), .state_o(state_o),
      .skid_level(skid_level), .skid_overflow(skid_overflow)
   );

   typedef struct {int tag; int seq; bit sb; bit sa;} ent_t;

   // reference model
   int   ms = 0;
   ent_t mq[$];
   ent_t mh;
   bit   mhv = 0, mres = 0, mpend = 0, movf = 0;
   bit   ev, eb, eu;
   int   etag = 0, eseq = 0;

   int    checks = 0, fails = 0, sn = 100;
   string req = "R1";
   bit    done = 0;

   task automatic chk(input string r, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s actual=%0d expected=%0d", r, what, act, exp);
      end
   endtask

   function automatic bit dry(input logic [CRED_W-1:0] c);
      return $signed(c) <= 0;
   endfunction

   task automatic mpush_back(input ent_t e);
      if (mq.size() >= CAP) movf = 1; else mq.push_back(e);
   endtask

   task automatic mpush_front(input ent_t e);
      if (mq.size() >= CAP) movf = 1; else mq.push_front(e);
   endtask

   task automatic model_eval();
      bit   quiet, stall, step, have, from_q, to_ser, pw;
      int   ns;
      ent_t a, src, h;
      quiet = rob_empty && pipe_idle;
      stall = later_block || commit_block || dry(rob_cred) || dry(iq_cred) ||
              dry(lsq_cred) || !regs_ok || (ms == 5 && !quiet);
      a = '{int'(in_tag), int'(in_seq), in_ser_before, in_ser_after};
      ev = 0; eb = 0; eu = 0; ns = ms; step = 0;
      if (squash) begin
         mq.delete(); ns = 4;
         if (ms == 5) begin
            if (mhv && mh.seq <= int'(squash_seq)) mres = 1;
            else begin mhv = 0; mres = 0; eu = 1; end
         end else if (ms != 4) begin
            mhv = 0; mres = 0;
            if (ms == 2 || ms == 3) eu = 1;
         end
      end else if (rob_squashing) begin
         ns = 4;
      end else if (stall) begin
         if (in_valid) mpush_back(a);
         if (ms == 4 && mres) begin ns = 5; mres = 0; eb = 1; end
         else begin
            if (ms != 2 && ms != 5) eb = 1;
            if (ms != 5) ns = 2;
         end
      end else if (ms == 2) begin
         if (in_valid) mpush_back(a);
         ns = 3;
      end else if (ms == 4 && mres) begin
         ns = 5; mres = 0; eb = 1;
         if (in_valid) mpush_back(a);
      end else if (ms == 5) begin
         h = mh; h.sb = 0; h.sa = 0; mhv = 0;
         if (mq.size() > 0) begin
            mpush_front(h);
            if (in_valid) mpush_back(a);
            ns = 3;
         end else begin
            ev = 1; etag = mh.tag; eseq = mh.seq;
            if (in_valid) begin mpush_back(a); ns = 3; end
            else begin ns = 1; eu = 1; end
         end
      end else step = 1;

      if (step) begin
         from_q = mq.size() > 0;
         if (from_q) begin src = mq.pop_front(); if (in_valid) mpush_back(a); end
         else src = a;
         have = from_q || in_valid;
         to_ser = 0;
         if (have) begin
            pw = mpend; mpend = 0;
            if (src.sb || (pw && !quiet)) begin
               mh = src; mhv = 1; ns = 5; eb = 1; to_ser = 1;
            end else begin
               ev = 1; etag = src.tag; eseq = src.seq;
               if (src.sa) mpend = 1;
            end
         end
         if (!to_ser) begin
            if (ms == 3) begin
               if (mq.size() == 0) begin ns = 1; eu = 1; end
            end else if (have || ms == 4) ns = 1;
         end
      end
      ms = ns;
   endtask

   task automatic compare();
      chk(req, "state", int'(state_o), ms);
      chk(req, "skid_level", int'(skid_level), mq.size());
      chk(req, "out_valid", int'(out_valid), int'(ev));
      chk(req, "dec_block", int'(dec_block), int'(eb));
      chk(req, "dec_unblock", int'(dec_unblock), int'(eu));
      chk(req, "skid_overflow", int'(skid_overflow), int'(movf));
      if (ev && out_valid) begin
         chk(req, "out_tag", int'(out_tag), etag & 8'hFF);
         chk(req, "out_seq", int'(out_seq), eseq);
      end
   endtask

   task automatic tick(input bit v, input bit sb = 0, input bit sa = 0);
      in_valid = v; in_ser_before = sb; in_ser_after = sa;
      in_tag = TAG_W'(sn * 7); in_seq = SEQ_W'(sn);
      if (v) sn++;
      model_eval();
      @(posedge clk);
      #1;
      compare();
      @(negedge clk);
      in_valid = 0; in_ser_before = 0; in_ser_after = 0;
   endtask

   task automatic send(input int n);
      for (int i = 0; i < n; i++) tick(1);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) tick(0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      int held_sn;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1;
      // R1 reset state
      chk("R1", "state", int'(state_o), 0);
      chk("R1", "skid_level", int'(skid_level), 0);
      chk("R1", "out_valid", int'(out_valid), 0);
      chk("R1", "pulses", int'(dec_block) + int'(dec_unblock), 0);
      chk("R1", "skid_overflow", int'(skid_overflow), 0);

      req = "R12"; send(3); idle(1);

      req = "R3"; later_block = 1; send(2);
      req = "R4"; later_block = 0; send(1);
      req = "R5"; send(2); idle(4);

      req = "R3"; iq_cred = 6'd0; send(1); iq_cred = 6'd4; idle(3);
      rob_cred = 6'h3F; send(1); rob_cred = 6'd4; idle(3);
      regs_ok = 0; send(1); regs_ok = 1; idle(3);
      commit_block = 1; idle(1); send(1); commit_block = 0; idle(3);

      req = "R7"; rob_empty = 0; tick(1, 1); send(2); idle(1);
      req = "R8"; rob_empty = 1; idle(1); idle(4);
      req = "R7"; rob_empty = 0; tick(1, 1); idle(2);
      req = "R8"; rob_empty = 1; idle(2);
      req = "R7"; pipe_idle = 0; tick(1, 1); idle(1);
      req = "R8"; pipe_idle = 1; send(1); idle(3);

      req = "R9"; rob_empty = 0; tick(1, 0, 1); send(1); idle(1);
      rob_empty = 1; idle(2);
      tick(1, 0, 1); send(1); idle(1);

      req = "R10"; rob_empty = 0; held_sn = sn; tick(1, 1); send(2);
      squash = 1; squash_seq = SEQ_W'(held_sn); tick(1); squash = 0;
      req = "R11"; send(1); idle(1);
      rob_empty = 1; idle(4);

      req = "R10"; rob_empty = 0; held_sn = sn; tick(1, 1); send(1);
      squash = 1; squash_seq = SEQ_W'(held_sn - 1); tick(0); squash = 0;
      rob_empty = 1;
      req = "R11"; send(1); idle(2);

      req = "R10"; later_block = 1; send(2); later_block = 0;
      squash = 1; squash_seq = SEQ_W'(sn); tick(1); squash = 0;
      req = "R11"; send(1); idle(2);

      req = "R2"; rob_squashing = 1; send(2);
      squash = 1; later_block = 1; tick(1); squash = 0; later_block = 0;
      rob_squashing = 0; idle(1); send(1); idle(1);

      req = "R6"; later_block = 1; send(CAP + 2); later_block = 0; idle(CAP + 3);

      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule